// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by walking a two-level translation structure kept in ordinary memory. A request carries the linear address, a write flag and a user flag. The walker fetches the first-level entry, then the second-level entry, and checks presence and user permissions. On success it writes back the accessed and dirty markers and returns the physical address. On failure it reports a page fault, keeps the faulting linear address and gives a three-bit code that describes the fault.

The first-level table starts at the 4 KB frame given on `dir_base`. Each level has 1024 four-byte entries. The walker has one memory access outstanding at a time, on a single port with a valid/ready handshake. A read returns its data in the cycle where valid and ready are both high.

Entry bit layout, shared with the software that builds the tables: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty (second level only), bits 11:9 free for software, bits 31:12 the frame number.

Top module: `pt_walker`

## Requirements
- R1: The first read goes to byte address {dir_base, vaddr[31:22], 2'b00}.
- R2: The second read goes to {first_entry[31:12], vaddr[21:12], 2'b00}. On success rsp_paddr = {second_entry[31:12], vaddr[11:0]}.
- R3: A clear present bit (bit 0) in either entry ends the walk with rsp_fault=1, and fault_addr takes the linear address. A missing first-level entry makes no second read.
- R4: For a user access (req_user=1) the user bit (bit 2) and writable bit (bit 1) are ANDed across both levels. user=0 denies every access. user=1 with writable=0 allows reads only. user=1 with writable=1 allows reads and writes.
- R5: A supervisor access (req_user=0) to a present page always succeeds, whatever the user and writable bits are.
- R6: After a successful check, each entry whose accessed bit (bit 5) is clear is written back with it set: first-level entry first, then second-level entry. An entry that already has it set is not written.
- R7: The dirty bit (bit 6) is set only in the second-level entry, and only for a write. A read leaves it unchanged.
- R8: A faulting walk writes no memory. fault_code = {user, write, present}, where bit 0 is 1 when both entries were present, so the fault is a protection fault.
- R9: Bits 11:9 of an entry do not affect the translation and are kept unchanged in write-backs.
- R10: Once mem_valid is raised, it stays high with mem_addr and mem_write unchanged until mem_ready. req_ready is high only while the walker is idle, and then no memory access is pending.
- R11: rsp_valid is a one-cycle pulse per request. fault_addr and fault_code hold their values until the next fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_base | input | 20 | Frame number of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-level access |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts; read data valid |
| mem_write | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Walk finished (one cycle) |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_paddr | output | 32 | Physical address on success |
| fault_addr | output | 32 | Linear address of the latest fault |
| fault_code | output | 3 | {user, write, present} of the latest fault |

## Verification
On every cycle the embedded properties check the memory handshake discipline, that req_ready means no access is pending, that the response lasts one cycle, that every write-back carries the accessed bit, that a read never sets the dirty bit, and that a reported fault shows the request's address. The permission table, the AND across levels, write-back ordering and skipping, fault codes, the absence of writes on a fault, and the preserved software bits depend on table contents in memory. Only the directed scenarios show these, by checking the returned address and the memory image after each walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31-OFF_W:0]      dir_base,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [31:0]            req_vaddr,
  input  logic                   req_write,
  input  logic                   req_user,
  output logic                   mem_valid,
  input  logic                   mem_ready,
  output logic                   mem_write,
  output logic [31:0]            mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic [31:0]            mem_rdata,
  output logic                   rsp_valid,
  output logic                   rsp_fault,
  output logic [31:0]            rsp_paddr,
  output logic [31:0]            fault_addr,
  output logic [2:0]             fault_code
);
  localparam int B_P  = 0;
  localparam int B_RW = 1;
  localparam int B_US = 2;
  localparam int B_A  = 5;
  localparam int B_D  = 6;
  localparam int DIR_LO = OFF_W + IDX_W;
  localparam logic [31:0] M_A = 32'(1) << B_A;
  localparam logic [31:0] M_D = 32'(1) << B_D;

  typedef enum logic [2:0] {S_IDLE, S_PDE, S_PTE, S_UPD, S_DONE, S_FLT} st_t;

  st_t         st;
  logic [31:0] va_q, pde_q, pte_q;
  logic        wr_q, usr_q, upd_pte;

  logic [31:0] pde_addr, pte_addr;
  logic        perm_ok, need_pde, need_pte_rd, need_pte_q, hs;

  assign pde_addr = {dir_base, va_q[31:DIR_LO], 2'b00};
  assign pte_addr = {pde_q[31:OFF_W], va_q[DIR_LO-1:OFF_W], 2'b00};
  assign hs       = mem_valid && mem_ready;

  assign perm_ok = !usr_q ||
                   (pde_q[B_US] && mem_rdata[B_US] &&
                    (!wr_q || (pde_q[B_RW] && mem_rdata[B_RW])));
  assign need_pde    = !pde_q[B_A];
  assign need_pte_rd = !mem_rdata[B_A] || (wr_q && !mem_rdata[B_D]);
  assign need_pte_q  = !pte_q[B_A] || (wr_q && !pte_q[B_D]);

  assign req_ready = (st == S_IDLE);
  assign mem_valid = (st == S_PDE) || (st == S_PTE) || (st == S_UPD);
  assign mem_write = (st == S_UPD);
  assign mem_addr  = (st == S_PTE || (st == S_UPD && upd_pte)) ? pte_addr : pde_addr;
  assign mem_wdata = upd_pte ? (pte_q | M_A | (wr_q ? M_D : 32'h0)) : (pde_q | M_A);
  assign rsp_valid = (st == S_DONE) || (st == S_FLT);
  assign rsp_fault = (st == S_FLT);
  assign rsp_paddr = {pte_q[31:OFF_W], va_q[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      va_q       <= '0;
      pde_q      <= '0;
      pte_q      <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      upd_pte    <= 1'b0;
      fault_addr <= '0;
      fault_code <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          usr_q <= req_user;
          st    <= S_PDE;
        end
        S_PDE: if (hs) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[B_P]) begin
            fault_addr <= va_q;
            fault_code <= {usr_q, wr_q, 1'b0};
            st         <= S_FLT;
          end else begin
            st <= S_PTE;
          end
        end
        S_PTE: if (hs) begin
          pte_q <= mem_rdata;
          if (!mem_rdata[B_P] || !perm_ok) begin
            fault_addr <= va_q;
            fault_code <= {usr_q, wr_q, mem_rdata[B_P]};
            st         <= S_FLT;
          end else if (need_pde) begin
            upd_pte <= 1'b0;
            st      <= S_UPD;
          end else if (need_pte_rd) begin
            upd_pte <= 1'b1;
            st      <= S_UPD;
          end else begin
            st <= S_DONE;
          end
        end
        S_UPD: if (hs) begin
          if (!upd_pte && need_pte_q) upd_pte <= 1'b1;
          else begin
            upd_pte <= 1'b0;
            st      <= S_DONE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !rsp_valid);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> mem_wdata[B_A]);

  a_r7_no_dirty_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && upd_pte && !wr_q |-> mem_wdata[B_D] == pte_q[B_D]);

  a_r3_fault_address: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> fault_addr == va_q);
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] dir_base = 20'h00010;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, mem_valid, mem_write, rsp_valid, rsp_fault;
  logic        mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rsp_paddr, fault_addr;
  logic [2:0]  fault_code;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fault_addr(fault_addr), .fault_code(fault_code)
  );

  always #2.5 clk = ~clk;

  logic [31:0] mem [logic [29:0]];
  int n_rd, n_wr, mem_lat, lat_cnt;
  int tests = 0, fails = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a[31:2]) ? mem[a[31:2]] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0; mem_rdata <= '0; lat_cnt <= 0;
    end else if (mem_valid && mem_ready) begin
      mem_ready <= 1'b0; lat_cnt <= 0;
      if (mem_write) begin mem[mem_addr[31:2]] = mem_wdata; n_wr = n_wr + 1; end
      else n_rd = n_rd + 1;
    end else if (mem_valid) begin
      if (lat_cnt >= mem_lat) begin mem_ready <= 1'b1; mem_rdata <= rd(mem_addr); end
      else lat_cnt <= lat_cnt + 1;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1; tests = tests + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] va(input int d, input int t, input int o);
    return {d[9:0], t[9:0], o[11:0]};
  endfunction

  logic        r_fault;
  logic [31:0] r_paddr;

  task automatic walk(input logic [31:0] a, input logic w, input logic u);
    int n = 0;
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_vaddr = a; req_write = w; req_user = u; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 500) begin @(negedge clk); n++; end
    r_fault = rsp_fault; r_paddr = rsp_paddr;
    @(negedge clk);
    chk("R11 pulse ends", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R10 ready after reset", {31'b0, req_ready}, 32'h1);
    chk("R10 no access after reset", {31'b0, mem_valid}, 32'h0);
    chk("R11 no response after reset", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_sup_read;
    walk(va(1, 2, 12'h345), 1'b0, 1'b0);
    chk("R2 paddr", r_paddr, 32'h12345345);
    chk("R1 R2 two reads", n_rd, 2);
    chk("R6 two write-backs", n_wr, 2);
    chk("R6 R9 first entry", mem[30'h10004 >> 2], 32'h00020E21);
    chk("R7 R9 second entry no dirty", mem[30'h20008 >> 2], 32'h12345E21);
  endtask

  task automatic t_user_write;
    walk(va(2, 3, 12'hABC), 1'b1, 1'b1);
    chk("R4 rw page write ok", {31'b0, r_fault}, 32'h0);
    chk("R2 paddr", r_paddr, 32'h0ABCDABC);
    chk("R7 dirty set", mem[30'h2100C >> 2], 32'h0ABCD067);
    chk("R6 first entry accessed", mem[30'h10008 >> 2], 32'h00021027);
    walk(va(2, 3, 12'hABC), 1'b1, 1'b1);
    chk("R6 no write-back when set", n_wr, 0);
    chk("R2 paddr repeat", r_paddr, 32'h0ABCDABC);
  endtask

  task automatic t_not_present;
    walk(va(5, 0, 12'h010), 1'b1, 1'b1);
    chk("R3 fault dir", {31'b0, r_fault}, 32'h1);
    chk("R3 one read only", n_rd, 1);
    chk("R8 no writes", n_wr, 0);
    chk("R8 code", {29'b0, fault_code}, 32'h6);
    chk("R3 fault_addr", fault_addr, va(5, 0, 12'h010));
    walk(va(2, 7, 12'h020), 1'b0, 1'b0);
    chk("R3 fault table", {31'b0, r_fault}, 32'h1);
    chk("R8 code table", {29'b0, fault_code}, 32'h0);
    chk("R3 fault_addr table", fault_addr, va(2, 7, 12'h020));
  endtask

  task automatic t_user_perm;
    walk(va(2, 8, 12'h000), 1'b0, 1'b1);
    chk("R4 read-only page read", {31'b0, r_fault}, 32'h0);
    chk("R4 paddr", r_paddr, 32'h66666000);
    chk("R6 only second written", n_wr, 1);
    walk(va(2, 8, 12'h000), 1'b1, 1'b1);
    chk("R4 read-only page write faults", {31'b0, r_fault}, 32'h1);
    chk("R8 protection code", {29'b0, fault_code}, 32'h7);
    chk("R8 no writes on fault", n_wr, 0);
    walk(va(3, 0, 12'h000), 1'b1, 1'b1);
    chk("R4 AND of writable", {31'b0, r_fault}, 32'h1);
    chk("R8 entry untouched", mem[30'h1000C >> 2], 32'h00022005);
    walk(va(1, 2, 12'h345), 1'b0, 1'b1);
    chk("R4 user bit clear denies", {31'b0, r_fault}, 32'h1);
    chk("R8 code user read", {29'b0, fault_code}, 32'h5);
  endtask

  task automatic t_supervisor;
    walk(va(1, 4, 12'h0FF), 1'b1, 1'b0);
    chk("R5 supervisor write ok", {31'b0, r_fault}, 32'h0);
    chk("R5 paddr", r_paddr, 32'h777770FF);
    chk("R7 dirty on write", mem[30'h20010 >> 2], 32'h77777061);
    chk("R11 fault_addr held", fault_addr, va(1, 2, 12'h345));
    chk("R11 fault_code held", {29'b0, fault_code}, 32'h5);
  endtask

  task automatic t_slow_mem;
    mem_lat = 3;
    walk(va(2, 3, 12'h001), 1'b0, 1'b1);
    chk("R10 slow memory paddr", r_paddr, 32'h0ABCD001);
    chk("R10 slow memory reads", n_rd, 2);
    mem_lat = 0;
  endtask

  initial begin
    n_rd = 0; n_wr = 0; mem_lat = 0;
    mem[30'h10004 >> 2] = 32'h00020E01;
    mem[30'h20008 >> 2] = 32'h12345E01;
    mem[30'h10008 >> 2] = 32'h00021007;
    mem[30'h2100C >> 2] = 32'h0ABCD007;
    mem[30'h2101C >> 2] = 32'h55555006;
    mem[30'h21020 >> 2] = 32'h66666005;
    mem[30'h1000C >> 2] = 32'h00022005;
    mem[30'h22000 >> 2] = 32'h88888007;
    mem[30'h20010 >> 2] = 32'h77777001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_sup_read;
    t_user_write;
    t_not_present;
    t_user_perm;
    t_supervisor;
    t_slow_mem;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule